// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block sits on the device side of a parallel NOR flash data bus. While an embedded program or erase runs, it overlays three status bits on the word returned to the host. Bit 7 is a polarity flag. Bit 6 is a general toggle. Bit 2 is a sector toggle. The host polls these bits to learn whether the operation is still in progress, whether an erase has been suspended, and whether the word it is reading belongs to the suspended sector. When nothing is running, the array word passes through unchanged.

The embedded program and erase timing is modelled by two busy counters, with durations set by parameters. The erase counter freezes while the erase is suspended. A program may be started inside an erase suspension. The command decoder that issues the start and suspend controls, and the array storage itself, lie outside this block. Reads are marked by a read strobe, and a rising edge of that strobe counts as one read. After each completion, a settle window (a parameterised number of cycles) marks the bus as not yet fully valid.

Top module: `wrStatusGen`

## Requirements
- R1: While reset is asserted and directly after it, `progBusy`, `eraseBusy` are 0, `busValid` is 1 and `dataOut` equals `arrayData`.
- R2: An accepted `startProg` makes `progBusy` high for exactly PROG_CYCLES cycles, starting at the next clock edge. An accepted `startErase` makes `eraseBusy` high until ERASE_CYCLES unsuspended cycles have elapsed.
- R3: While a program runs outside any suspension, bit 7 of `dataOut` is the inverse of `progData[7]`. Bit 6 starts at 0 and flips after every read. Bit 2 holds its value. All other bits equal `arrayData`.
- R4: While an erase runs unsuspended and no program is busy, bit 7 is 0. Bits 6 and 2 each start at 0 and flip after every read. All other bits equal `arrayData`.
- R5: While an erase is pending with `suspendIn` high and no program busy, the erase count does not advance. A read with `inSuspSector` high shows bit 7 = 1 and bit 6 = 1, and bit 2 flips after each such read.
- R6: During an erase suspension with no program busy, a cycle with `inSuspSector` low shows `arrayData` on every bit.
- R7: `startProg` is accepted during an erase suspension. The program then shows inverted bit 7 and a toggling bit 6, while bit 2 holds.
- R8: `startProg` is ignored while a program is busy, and when an erase is pending without suspension. `startErase` is ignored while either operation is pending, while `suspendIn` is high, and when `startProg` is also high.
- R9: After any operation completes, `busValid` is 0 for exactly SETTLE_CYCLES cycles, and `dataOut` meanwhile follows `arrayData`.
- R10: With no operation pending, `dataOut` equals `arrayData` whatever `suspendIn`, `inSuspSector` and `readStrobe` do.
- R11: A toggle bit is cleared whenever its toggling condition ends, so the first read of each new operation or resumed erase shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startProg | input | 1 | Request to begin an embedded program |
| startErase | input | 1 | Request to begin an embedded erase |
| suspendIn | input | 1 | Erase suspension in force |
| inSuspSector | input | 1 | Current read address lies in the suspended sector |
| readStrobe | input | 1 | Read strobe; each rising edge is one read |
| progData | input | DW | Latched word being programmed |
| arrayData | input | DW | Word read from the array |
| dataOut | output | DW | Word driven onto the host data bus |
| progBusy | output | 1 | Program in progress |
| eraseBusy | output | 1 | Erase pending (running or suspended) |
| busValid | output | 1 | Low during the settle window after a completion |

## Verification
The bench builds the block with PROG_CYCLES = 5, ERASE_CYCLES = 8 and SETTLE_CYCLES = 3. These short values let every completion, settle window and toggle restart occur many times within a few hundred cycles. They also let a program begin and end entirely inside one erase suspension, with the frozen erase still pending afterwards. The bench varies the read strobe between single-cycle pulses, held levels and gaps, so that flips on rising edges alone can be told apart from flips on levels.

// File: rtl/wrStatusPkg.sv
package wrStatusPkg;

  localparam int POLL_BIT = 7;
  localparam int TGL_BIT  = 6;
  localparam int SEC_BIT  = 2;

  typedef struct packed {
    logic progBusy;
    logic eraseRun;
    logic eraseHeld;
  } statStrobes_t;

  typedef enum logic [1:0] {
    SHOW_ARRAY,
    SHOW_PROG,
    SHOW_ERASE,
    SHOW_SUSP
  } showMode_t;

endpackage

// File: rtl/wrStatusCtrl.sv
module wrStatusCtrl
  import wrStatusPkg::*;
#(
  parameter int PROG_CYCLES   = 20,
  parameter int ERASE_CYCLES  = 200,
  parameter int SETTLE_CYCLES = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startProg,
  input  logic         startErase,
  input  logic         suspendIn,
  output statStrobes_t strb,
  output logic         busValid
);

  localparam int PW = $clog2(PROG_CYCLES + 2);
  localparam int EW = $clog2(ERASE_CYCLES + 2);
  localparam int SW = $clog2(SETTLE_CYCLES + 2);

  logic [PW-1:0] progCnt;
  logic [EW-1:0] eraseCnt;
  logic [SW-1:0] settleCnt;

  logic progIdle, eraseIdle, progGo, eraseGo, progDone, eraseDone;

  always_comb begin
    progIdle  = (progCnt == '0);
    eraseIdle = (eraseCnt == '0);
    progGo    = startProg && progIdle && (eraseIdle || suspendIn);
    eraseGo   = startErase && !startProg && progIdle && eraseIdle && !suspendIn;
    progDone  = (progCnt == PW'(1));
    eraseDone = (eraseCnt == EW'(1)) && !suspendIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt <= '0;
    end else if (progGo) begin
      progCnt <= PW'(PROG_CYCLES);
    end else if (!progIdle) begin
      progCnt <= progCnt - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseCnt <= '0;
    end else if (eraseGo) begin
      eraseCnt <= EW'(ERASE_CYCLES);
    end else if (!eraseIdle && !suspendIn) begin
      eraseCnt <= eraseCnt - EW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (progDone || eraseDone) begin
      settleCnt <= SW'(SETTLE_CYCLES);
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - SW'(1);
    end
  end

  always_comb begin
    strb.progBusy  = !progIdle;
    strb.eraseRun  = !eraseIdle && !suspendIn;
    strb.eraseHeld = !eraseIdle && suspendIn;
    busValid       = (settleCnt == '0);
  end

endmodule

// File: rtl/wrStatusPath.sv
module wrStatusPath
  import wrStatusPkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  statStrobes_t  strb,
  input  logic          readStrobe,
  input  logic          inSuspSector,
  input  logic [DW-1:0] progData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] dataOut
);

  logic readPrev, readRise;
  logic tgl6, tgl2;
  logic eraseAct, tgl6Live, tgl2Live;
  showMode_t mode;

  always_comb begin
    readRise = readStrobe && !readPrev;
    eraseAct = strb.eraseRun || strb.eraseHeld;
    tgl6Live = strb.progBusy || strb.eraseRun;
    tgl2Live = !strb.progBusy &&
               (strb.eraseRun || (strb.eraseHeld && inSuspSector));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b0;
    end else begin
      readPrev <= readStrobe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgl6 <= 1'b0;
    end else if (!tgl6Live) begin
      tgl6 <= 1'b0;
    end else if (readRise) begin
      tgl6 <= !tgl6;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgl2 <= 1'b0;
    end else if (!eraseAct) begin
      tgl2 <= 1'b0;
    end else if (tgl2Live && readRise) begin
      tgl2 <= !tgl2;
    end
  end

  always_comb begin
    if (strb.progBusy) begin
      mode = SHOW_PROG;
    end else if (strb.eraseRun) begin
      mode = SHOW_ERASE;
    end else if (strb.eraseHeld && inSuspSector) begin
      mode = SHOW_SUSP;
    end else begin
      mode = SHOW_ARRAY;
    end
  end

  always_comb begin
    dataOut = arrayData;
    unique case (mode)
      SHOW_PROG: begin
        dataOut[POLL_BIT] = !progData[POLL_BIT];
        dataOut[TGL_BIT]  = tgl6;
        dataOut[SEC_BIT]  = tgl2;
      end
      SHOW_ERASE: begin
        dataOut[POLL_BIT] = 1'b0;
        dataOut[TGL_BIT]  = tgl6;
        dataOut[SEC_BIT]  = tgl2;
      end
      SHOW_SUSP: begin
        dataOut[POLL_BIT] = 1'b1;
        dataOut[TGL_BIT]  = 1'b1;
        dataOut[SEC_BIT]  = tgl2;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wrStatusGen.sv
module wrStatusGen
  import wrStatusPkg::*;
#(
  parameter int DW            = 16,
  parameter int PROG_CYCLES   = 20,
  parameter int ERASE_CYCLES  = 200,
  parameter int SETTLE_CYCLES = 50
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startProg,
  input  logic          startErase,
  input  logic          suspendIn,
  input  logic          inSuspSector,
  input  logic          readStrobe,
  input  logic [DW-1:0] progData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] dataOut,
  output logic          progBusy,
  output logic          eraseBusy,
  output logic          busValid
);

  statStrobes_t strb;

  wrStatusCtrl #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .startProg (startProg),
    .startErase(startErase),
    .suspendIn (suspendIn),
    .strb      (strb),
    .busValid  (busValid)
  );

  wrStatusPath #(
    .DW(DW)
  ) pathInst (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .readStrobe  (readStrobe),
    .inSuspSector(inSuspSector),
    .progData    (progData),
    .arrayData   (arrayData),
    .dataOut     (dataOut)
  );

  assign progBusy  = strb.progBusy;
  assign eraseBusy = strb.eraseRun || strb.eraseHeld;

endmodule

// File: rtl/wrStatusChk.sv
module wrStatusChk
  import wrStatusPkg::*;
#(
  parameter int DW            = 16,
  parameter int SETTLE_CYCLES = 50
) (
  input logic          clk,
  input logic          rstN,
  input logic          suspendIn,
  input logic          inSuspSector,
  input logic          readStrobe,
  input logic [DW-1:0] progData,
  input logic [DW-1:0] arrayData,
  input logic [DW-1:0] dataOut,
  input logic          progBusy,
  input logic          eraseBusy,
  input logic          busValid
);

  logic prevRd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRd <= 1'b0;
    else       prevRd <= readStrobe;
  end

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> (dataOut[POLL_BIT] == !progData[POLL_BIT]));

  assert_prog_flip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && readStrobe && !prevRd) |=>
      (!progBusy || (dataOut[TGL_BIT] != $past(dataOut[TGL_BIT]))));

  assert_prog_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && !(readStrobe && !prevRd)) |=>
      (!progBusy || $stable(dataOut[TGL_BIT])));

  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && !suspendIn && !progBusy) |-> !dataOut[POLL_BIT]);

  assert_susp_sector_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && suspendIn && inSuspSector && !progBusy) |->
      (dataOut[POLL_BIT] && dataOut[TGL_BIT]));

  assert_susp_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && suspendIn) |=> eraseBusy);

  assert_susp_other_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eraseBusy && suspendIn && !inSuspSector && !progBusy) |->
      (dataOut == arrayData));

  assert_idle_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!progBusy && !eraseBusy) |-> (dataOut == arrayData));

  generate
    if (SETTLE_CYCLES > 0) begin : gSettle
      assert_settle_low_R9: assert property (@(posedge clk) disable iff (!rstN)
        $fell(progBusy) |-> !busValid);
    end
  endgenerate

endmodule

bind wrStatusGen wrStatusChk #(
  .DW           (DW),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) chkInst (
  .clk         (clk),
  .rstN        (rstN),
  .suspendIn   (suspendIn),
  .inSuspSector(inSuspSector),
  .readStrobe  (readStrobe),
  .progData    (progData),
  .arrayData   (arrayData),
  .dataOut     (dataOut),
  .progBusy    (progBusy),
  .eraseBusy   (eraseBusy),
  .busValid    (busValid)
);

// File: tb/wrStatusGen_test.sv
module wrStatusGen_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int PROG_N     = 5;
  localparam int ERASE_N    = 8;
  localparam int SETTLE_N   = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startProg = 1'b0, startErase = 1'b0, suspendIn = 1'b0;
  logic          inSuspSector = 1'b0, readStrobe = 1'b0;
  logic [DW-1:0] progData = '0, arrayData = '0;
  logic [DW-1:0] dataOut;
  logic          progBusy, eraseBusy, busValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string note = "";

  // behavioural reference state
  int mProg = 0, mErase = 0, mSettle = 0;
  bit t6 = 0, t2 = 0, prevRd = 0;

  wrStatusGen #(
    .DW(DW), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N), .SETTLE_CYCLES(SETTLE_N)
  ) uut (
    .clk(clk), .rstN(rstN), .startProg(startProg), .startErase(startErase),
    .suspendIn(suspendIn), .inSuspSector(inSuspSector), .readStrobe(readStrobe),
    .progData(progData), .arrayData(arrayData), .dataOut(dataOut),
    .progBusy(progBusy), .eraseBusy(eraseBusy), .busValid(busValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic cmp(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, note, cycles, act, exp);
    end
  endtask

  // expected outputs from model state and current inputs
  task automatic compareNow();
    bit pb, er, eh;
    logic [DW-1:0] e;
    string tag;
    pb = (mProg != 0);
    er = (mErase != 0) && !suspendIn;
    eh = (mErase != 0) && suspendIn;
    e = arrayData;
    if (pb) begin
      e[7] = !progData[7]; e[6] = t6; e[2] = t2;
      tag = eh ? "R7" : "R3";
    end else if (er) begin
      e[7] = 1'b0; e[6] = t6; e[2] = t2; tag = "R4";
    end else if (eh && inSuspSector) begin
      e[7] = 1'b1; e[6] = 1'b1; e[2] = t2; tag = "R5";
    end else if (eh) begin
      tag = "R6";
    end else begin
      tag = "R10";
    end
    cmp(tag, dataOut, e);
    cmp("R2 progBusy", DW'(progBusy), DW'(pb));
    cmp("R2 eraseBusy", DW'(eraseBusy), DW'(mErase != 0));
    cmp("R9 busValid", DW'(busValid), DW'(mSettle == 0));
  endtask

  task automatic modelEdge();
    bit pb, er, eh, rise, done, pGo, eGo;
    pb = (mProg != 0);
    er = (mErase != 0) && !suspendIn;
    eh = (mErase != 0) && suspendIn;
    rise = readStrobe && !prevRd;
    if (pb || er) t6 = t6 ^ rise; else t6 = 0;
    if (mErase == 0) t2 = 0;
    else if (!pb && (er || (eh && inSuspSector)) && rise) t2 = !t2;
    prevRd = readStrobe;
    done = (mProg == 1) || (mErase == 1 && !suspendIn);
    pGo = startProg && (mProg == 0) && ((mErase == 0) || suspendIn);
    eGo = startErase && !startProg && (mProg == 0) && (mErase == 0) && !suspendIn;
    if (pGo) mProg = PROG_N; else if (mProg > 0) mProg--;
    if (eGo) mErase = ERASE_N; else if (mErase > 0 && !suspendIn) mErase--;
    if (done) mSettle = SETTLE_N; else if (mSettle > 0) mSettle--;
  endtask

  task automatic step(bit sp, bit se, bit su, bit ins, bit rd);
    startProg = sp; startErase = se; suspendIn = su;
    inSuspSector = ins; readStrobe = rd;
    arrayData = DW'(cycles * 16'h03B1) ^ 16'h5A5A;
    #1;
    compareNow();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    join_none

    // R1: reset state
    arrayData = 16'hC3E1;
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 dataOut", dataOut, 16'hC3E1);
    cmp("R1 progBusy", DW'(progBusy), '0);
    cmp("R1 eraseBusy", DW'(eraseBusy), '0);
    cmp("R1 busValid", DW'(busValid), DW'(1));
    @(negedge clk);
    rstN = 1'b1;

    // R10: idle pass-through with stray controls
    for (int i = 0; i < 8; i++) step(0, 0, i[0], i[1], i[2]);

    // R3: program with bit7 = 1, pulsed and held reads, R8 restart ignored
    progData = 16'h00A5;
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    note = "R8";
    step(1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 1);
    note = "";
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, i[0]);

    // R11: second program, bit7 = 0, toggle must restart at 0
    progData = 16'h1234;
    note = "R11";
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, (i % 3) != 2);
    note = "";

    // R4: erase with reads, R8 program start ignored while erasing
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, i[0]);
    note = "R8";
    step(1, 1, 0, 0, 1);
    note = "";
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, i[0]);

    // R5/R6/R7: erase, suspend, reads in and out of sector, program inside
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, i[0]);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, i[0]);
    note = "R8";
    step(0, 1, 1, 1, 0);
    note = "";
    progData = 16'h0080;
    step(1, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[1], i[0]);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, i[0]);
    note = "R11";
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, i[0]);
    note = "";

    // R8: simultaneous starts, program wins
    progData = 16'h7F00;
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, i[0]);

    // R10: idle again with suspend high and no erase pending
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, i[0]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule